// File: doc/BRIEF.md
# Transmit Descriptor Frame Sequencer

This block sits between a transmit descriptor fetch engine and the status write-back path of an Ethernet transmitter. Each descriptor handed to it carries a two-bit placement code saying whether its buffer opens a frame, continues one, closes one, or carries a whole frame alone, plus a flag that marks the final descriptor of the list. The sequencer keeps a single open-frame bit, pulses a start strobe and an end strobe at frame boundaries, and raises a one-cycle ordering fault whenever a code does not fit the current state or the list would end with a frame left open.

While a frame is open, error indications coming back from the MAC are gathered into a sticky four-bit set. When the closing descriptor is taken, the gathered set is merged with that cycle's indications and packed into a 32-bit word for the write-back of that descriptor. The word carries the placement code, a summary flag and the four error bits. A copy control decides whether the status part is filled in. The strobe for the word lasts one cycle, and the block refuses new descriptors during that cycle.

Top module: `tx_frame_seq`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises, frame_start, frame_end, seq_err and wb_valid are 0 and desc_ready is 1. No frame is open.
- R2: A descriptor is accepted on a rising clock edge where desc_valid and desc_ready are both 1. An accepted code 2'b10 (head) with no frame open and desc_last low opens a frame and pulses frame_start in the next cycle.
- R3: An accepted code 2'b11 (whole) with no frame open pulses frame_start, frame_end and wb_valid together in the next cycle, and leaves no frame open.
- R4: With a frame open, an accepted code 2'b00 (middle) with desc_last low keeps the frame open and pulses nothing. An accepted code 2'b01 (tail) closes the frame and pulses frame_end and wb_valid in the next cycle.
- R5: An accepted middle or tail code while no frame is open, or an accepted head or whole code while a frame is open, pulses seq_err in the next cycle with no other strobe. It leaves no frame open and discards the gathered errors.
- R6: An accepted descriptor with desc_last high whose code is head or middle (code bit 0 low) is a sequence error with the same effects as R5.
- R7: mac_err bits sampled with mac_err_vld high are OR-gathered on every cycle where a frame is open or a descriptor is accepted. At a close, wb_word[3:0] holds the set gathered up to and including the accepting cycle: bit 3 no carrier, bit 2 carrier lost, bit 1 late collision, bit 0 retry limit. The set is then empty for the next frame.
- R8: wb_word[27] is 1 exactly when any of wb_word[3:0] is 1.
- R9: wb_word[29:28] echo the closing descriptor's code, and bits 31:30 and 26:4 are 0. When copy_en is low in the accepting cycle, bits 27:0 are all 0.
- R10: wb_valid lasts exactly one cycle. desc_ready is 0 in that cycle, and a desc_valid presented then has no effect.
- R11: Error indications on cycles with no frame open and no descriptor accepted are discarded and never reach a later write-back word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| desc_valid | input | 1 | A descriptor is presented |
| desc_ready | output | 1 | The sequencer can take a descriptor this cycle |
| desc_pos | input | 2 | Placement code: 00 middle, 01 tail, 10 head, 11 whole |
| desc_last | input | 1 | Descriptor is the last in the list |
| mac_err_vld | input | 1 | mac_err is meaningful this cycle |
| mac_err | input | 4 | Error indications: 3 no carrier, 2 carrier lost, 1 late collision, 0 retry limit |
| copy_en | input | 1 | Fill the status part of the write-back word |
| frame_start | output | 1 | One-cycle pulse: a frame began |
| frame_end | output | 1 | One-cycle pulse: a frame closed |
| seq_err | output | 1 | One-cycle pulse: descriptor ordering fault |
| wb_valid | output | 1 | One-cycle write-back strobe |
| wb_word | output | 32 | Status word for the closing descriptor |

## Verification
A stuck or wrongly set open-frame bit shows at the ports on the very next accepted descriptor. A legal code then draws seq_err instead of a strobe, or an illegal code draws a strobe instead of seq_err, in the cycle after acceptance. A gathered error set that is not cleared, or that is filled while idle, only shows when the next frame closes, as extra bits in wb_word[3:0] and bit 27. The bench therefore runs short frames back to back after error-laden ones and idle spells. A lost ready gap shows as a second descriptor taken one cycle after a close.

// File: rtl/txfs_pkg.sv
package txfs_pkg;

  localparam int POS_W = 2;

  // placement code: bit 1 marks a frame head, bit 0 marks a frame tail
  typedef enum logic [POS_W-1:0] {
    POS_MID   = 2'b00,
    POS_TAIL  = 2'b01,
    POS_HEAD  = 2'b10,
    POS_WHOLE = 2'b11
  } pos_e;

  typedef struct packed {
    logic head;       // legal descriptor that opens a frame
    logic tail;       // legal descriptor that closes a frame
    logic bad_order;  // code does not fit the open/closed state
    logic bad_last;   // list ends while the frame would stay open
  } cls_t;

endpackage

// File: rtl/txfs_classify.sv
module txfs_classify
  import txfs_pkg::*;
(
  input  logic open_i,
  input  pos_e pos_i,
  input  logic last_i,
  output cls_t cls_o
);

  logic code_head;
  logic code_tail;
  logic bad;

  always_comb begin
    code_head = 1'b0;
    code_tail = 1'b0;
    unique case (pos_i)
      POS_MID:   begin code_head = 1'b0; code_tail = 1'b0; end
      POS_TAIL:  begin code_head = 1'b0; code_tail = 1'b1; end
      POS_HEAD:  begin code_head = 1'b1; code_tail = 1'b0; end
      POS_WHOLE: begin code_head = 1'b1; code_tail = 1'b1; end
      default:   begin code_head = 1'b0; code_tail = 1'b0; end
    endcase
  end

  always_comb begin
    cls_o           = '0;
    cls_o.bad_order = (code_head == open_i);
    cls_o.bad_last  = last_i & ~code_tail;
    bad             = cls_o.bad_order | cls_o.bad_last;
    cls_o.head      = code_head & ~bad;
    cls_o.tail      = code_tail & ~bad;
  end

endmodule

// File: rtl/txfs_err_accum.sv
module txfs_err_accum #(
  parameter int ERR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic             clr_i,
  input  logic             err_vld_i,
  input  logic [ERR_W-1:0] err_i,
  output logic [ERR_W-1:0] acc_o,
  output logic [ERR_W-1:0] merged_o
);

  logic [ERR_W-1:0] acc_q;
  logic [ERR_W-1:0] acc_d;

  for (genvar b = 0; b < ERR_W; b++) begin : g_bit
    logic hit;
    assign hit         = err_vld_i & err_i[b];
    assign merged_o[b] = acc_q[b] | hit;

    always_comb begin
      acc_d[b] = acc_q[b];
      if (clr_i) begin
        acc_d[b] = 1'b0;
      end else if (cap_i) begin
        acc_d[b] = merged_o[b];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (cap_i | clr_i) begin
      acc_q <= acc_d;
    end
  end

  assign acc_o = acc_q;

  // R7
  clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (acc_o == '0));

endmodule

// File: rtl/txfs_wb_pack.sv
module txfs_wb_pack
  import txfs_pkg::*;
#(
  parameter int ERR_W   = 4,
  parameter int WB_W    = 32,
  parameter int SUM_BIT = 27,
  parameter int POS_LSB = 28
) (
  input  pos_e             pos_i,
  input  logic [ERR_W-1:0] err_i,
  input  logic             copy_i,
  output logic [WB_W-1:0]  word_o
);

  always_comb begin
    word_o                   = '0;
    word_o[POS_LSB +: POS_W] = pos_i;
    if (copy_i) begin
      word_o[SUM_BIT]     = |err_i;
      word_o[ERR_W-1:0]   = err_i;
    end
  end

endmodule

// File: rtl/tx_frame_seq.sv
module tx_frame_seq
  import txfs_pkg::*;
#(
  parameter int ERR_W   = 4,
  parameter int WB_W    = 32,
  parameter int SUM_BIT = 27,
  parameter int POS_LSB = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             desc_valid,
  output logic             desc_ready,
  input  logic [1:0]       desc_pos,
  input  logic             desc_last,
  input  logic             mac_err_vld,
  input  logic [ERR_W-1:0] mac_err,
  input  logic             copy_en,
  output logic             frame_start,
  output logic             frame_end,
  output logic             seq_err,
  output logic             wb_valid,
  output logic [WB_W-1:0]  wb_word
);

  pos_e             pos;
  cls_t             cls;
  logic             take;
  logic             fault;
  logic             open_q, open_d;
  logic             fs_q, fs_d;
  logic             fe_q, fe_d;
  logic             se_q, se_d;
  logic             wbv_q, wbv_d;
  logic [WB_W-1:0]  wbw_q, wbw_d;
  logic             wbw_en;
  logic             acc_cap, acc_clr;
  logic [ERR_W-1:0] acc_now;
  logic [ERR_W-1:0] acc_merged;

  assign pos        = pos_e'(desc_pos);
  assign desc_ready = ~wbv_q;
  assign take       = desc_valid & desc_ready;

  txfs_classify u_classify (
    .open_i (open_q),
    .pos_i  (pos),
    .last_i (desc_last),
    .cls_o  (cls)
  );

  assign fault   = cls.bad_order | cls.bad_last;
  assign acc_cap = open_q | take;
  assign acc_clr = take & (fault | cls.tail);

  txfs_err_accum #(.ERR_W(ERR_W)) u_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_i     (acc_cap),
    .clr_i     (acc_clr),
    .err_vld_i (mac_err_vld),
    .err_i     (mac_err),
    .acc_o     (acc_now),
    .merged_o  (acc_merged)
  );

  txfs_wb_pack #(
    .ERR_W   (ERR_W),
    .WB_W    (WB_W),
    .SUM_BIT (SUM_BIT),
    .POS_LSB (POS_LSB)
  ) u_pack (
    .pos_i  (pos),
    .err_i  (acc_merged),
    .copy_i (copy_en),
    .word_o (wbw_d)
  );

  // next-state logic
  always_comb begin
    open_d = open_q;
    if (take) begin
      if (fault) begin
        open_d = 1'b0;
      end else if (cls.tail) begin
        open_d = 1'b0;
      end else if (cls.head) begin
        open_d = 1'b1;
      end
    end
    fs_d   = take & cls.head;
    fe_d   = take & cls.tail;
    se_d   = take & fault;
    wbv_d  = take & cls.tail;
    wbw_en = take & cls.tail;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      fs_q   <= 1'b0;
      fe_q   <= 1'b0;
      se_q   <= 1'b0;
      wbv_q  <= 1'b0;
    end else begin
      open_q <= open_d;
      fs_q   <= fs_d;
      fe_q   <= fe_d;
      se_q   <= se_d;
      wbv_q  <= wbv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbw_q <= '0;
    end else if (wbw_en) begin
      wbw_q <= wbw_d;
    end
  end

  assign frame_start = fs_q;
  assign frame_end   = fe_q;
  assign seq_err     = se_q;
  assign wb_valid    = wbv_q;
  assign wb_word     = wbw_q;

  // R10
  wb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !wb_valid);

  // R4
  end_has_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> wb_valid);

  // R5
  fault_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |-> (!frame_start && !frame_end && !wb_valid));

  // R2
  start_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> $past(desc_valid));

  // R7
  acc_empty_at_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (acc_now == '0));

  // R8
  summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_word[SUM_BIT] == (wb_word[ERR_W-1:0] != '0)));

endmodule

// File: tb/test_tx_frame_seq.sv
`timescale 1ns/1ps
module test_tx_frame_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        desc_valid;
  logic        desc_ready;
  logic [1:0]  desc_pos;
  logic        desc_last;
  logic        mac_err_vld;
  logic [3:0]  mac_err;
  logic        copy_en;
  logic        frame_start;
  logic        frame_end;
  logic        seq_err;
  logic        wb_valid;
  logic [31:0] wb_word;

  int n_chk  = 0;
  int n_fail = 0;

  bit       m_open = 1'b0;
  bit [3:0] m_acc  = 4'h0;
  bit       m_wbv  = 1'b0;

  always #2.5 clk = ~clk;

  tx_frame_seq i_tx_frame_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .desc_valid  (desc_valid),
    .desc_ready  (desc_ready),
    .desc_pos    (desc_pos),
    .desc_last   (desc_last),
    .mac_err_vld (mac_err_vld),
    .mac_err     (mac_err),
    .copy_en     (copy_en),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .seq_err     (seq_err),
    .wb_valid    (wb_valid),
    .wb_word     (wb_word)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit [31:0] exp_word(bit [1:0] p, bit [3:0] e, bit ce);
    bit [31:0] w = '0;
    w[29:28] = p;
    if (ce) begin
      w[27]  = |e;
      w[3:0] = e;
    end
    return w;
  endfunction

  task automatic step(input bit v, input bit [1:0] p, input bit l,
                      input bit ev, input bit [3:0] e, input bit ce,
                      input string wtag);
    bit acc, bad_o, bad_l, bad, x_fs, x_fe, x_se;
    bit [3:0] ef, merged;
    bit [31:0] xw;
    desc_valid  = v;
    desc_pos    = p;
    desc_last   = l;
    mac_err_vld = ev;
    mac_err     = e;
    copy_en     = ce;
    #0.5;
    chk(desc_ready == !m_wbv, "R10", "desc_ready", desc_ready, !m_wbv);
    acc    = v & !m_wbv;
    bad_o  = (p[1] == m_open);
    bad_l  = l & !p[0];
    bad    = bad_o | bad_l;
    ef     = ev ? e : 4'h0;
    x_fs   = acc & p[1] & !bad;
    x_fe   = acc & p[0] & !bad;
    x_se   = acc & bad;
    merged = m_acc | ef;
    xw     = exp_word(p, merged, ce);
    if (acc & (bad | p[0])) m_acc = 4'h0;
    else if (m_open | acc)  m_acc = merged;
    if (acc) begin
      if (bad)       m_open = 1'b0;
      else if (p[0]) m_open = 1'b0;
      else if (p[1]) m_open = 1'b1;
    end
    m_wbv = x_fe;
    @(posedge clk);
    @(negedge clk);
    chk(frame_start == x_fs, (p == 2'b11) ? "R3" : "R2", "frame_start", frame_start, x_fs);
    chk(frame_end == x_fe, (p == 2'b11) ? "R3" : "R4", "frame_end", frame_end, x_fe);
    chk(seq_err == x_se, (bad_l && !bad_o) ? "R6" : "R5", "seq_err", seq_err, x_se);
    chk(wb_valid == x_fe, "R10", "wb_valid", wb_valid, x_fe);
    if (x_fe) begin
      chk(wb_word == xw, wtag, "wb_word", wb_word, xw);
      chk(wb_word[27] == (ce & |merged), "R8", "summary bit", wb_word[27], ce & |merged);
    end
  endtask

  task automatic idle();
    step(1'b0, 2'b00, 1'b0, 1'b0, 4'h0, 1'b1, "R7");
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed        = $urandom(32'd2718);
    rst_n       = 1'b0;
    desc_valid  = 1'b0;
    desc_pos    = 2'b00;
    desc_last   = 1'b0;
    mac_err_vld = 1'b0;
    mac_err     = 4'h0;
    copy_en     = 1'b1;
    repeat (3) @(negedge clk);
    chk(frame_start == 1'b0 && frame_end == 1'b0 && seq_err == 1'b0 && wb_valid == 1'b0,
        "R1", "strobes in reset", {frame_start, frame_end, seq_err, wb_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(desc_ready == 1'b1, "R1", "ready after reset", desc_ready, 1);
    chk(wb_valid == 1'b0 && seq_err == 1'b0, "R1", "strobes after reset",
        {wb_valid, seq_err}, 0);

    // R11: idle errors are dropped
    step(1'b0, 2'b00, 1'b0, 1'b1, 4'hF, 1'b1, "R11");
    step(1'b0, 2'b00, 1'b0, 1'b1, 4'h9, 1'b1, "R11");
    step(1'b1, 2'b11, 1'b0, 1'b0, 4'h0, 1'b1, "R11");
    idle();
    // R3 whole frame with errors
    step(1'b1, 2'b11, 1'b0, 1'b1, 4'h5, 1'b1, "R7");
    idle();
    // R2/R4/R7 multi-descriptor frame
    step(1'b1, 2'b10, 1'b0, 1'b1, 4'h1, 1'b1, "R7");
    step(1'b0, 2'b00, 1'b0, 1'b1, 4'h2, 1'b1, "R7");
    step(1'b1, 2'b00, 1'b0, 1'b0, 4'h0, 1'b1, "R7");
    step(1'b1, 2'b01, 1'b1, 1'b1, 4'h8, 1'b1, "R7");
    idle();
    // R9 copy disabled
    step(1'b1, 2'b11, 1'b0, 1'b1, 4'hF, 1'b0, "R9");
    idle();
    // R5 ordering faults
    step(1'b1, 2'b00, 1'b0, 1'b0, 4'h0, 1'b1, "R5");
    step(1'b1, 2'b01, 1'b0, 1'b0, 4'h0, 1'b1, "R5");
    step(1'b1, 2'b10, 1'b0, 1'b1, 4'h4, 1'b1, "R5");
    step(1'b1, 2'b10, 1'b0, 1'b0, 4'h0, 1'b1, "R5");
    step(1'b1, 2'b10, 1'b0, 1'b1, 4'h2, 1'b1, "R5");
    step(1'b1, 2'b11, 1'b0, 1'b0, 4'h0, 1'b1, "R5");
    step(1'b1, 2'b11, 1'b0, 1'b0, 4'h0, 1'b1, "R7");
    idle();
    // R6 end-of-list faults
    step(1'b1, 2'b11, 1'b1, 1'b0, 4'h0, 1'b1, "R6");
    idle();
    step(1'b1, 2'b10, 1'b1, 1'b0, 4'h0, 1'b1, "R6");
    step(1'b1, 2'b10, 1'b0, 1'b0, 4'h0, 1'b1, "R6");
    step(1'b1, 2'b00, 1'b1, 1'b0, 4'h0, 1'b1, "R6");
    // R10 descriptor offered during write-back is ignored
    step(1'b1, 2'b11, 1'b0, 1'b0, 4'h0, 1'b1, "R10");
    step(1'b1, 2'b11, 1'b0, 1'b1, 4'h3, 1'b1, "R10");
    step(1'b1, 2'b11, 1'b0, 1'b0, 4'h0, 1'b1, "R10");
    idle();

    for (int i = 0; i < 4000; i++) begin
      bit [1:0] p;
      if ($urandom % 10 < 8) begin
        if (m_open) p = ($urandom % 3 == 0) ? 2'b01 : 2'b00;
        else        p = ($urandom % 3 == 0) ? 2'b10 : 2'b11;
      end else begin
        p = 2'($urandom % 4);
      end
      step(($urandom % 5) != 0, p, ($urandom % 12) == 0,
           ($urandom % 3) == 0, 4'($urandom), ($urandom % 6) != 0, "R7");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule